// File: doc/BRIEF.md
# Statistical Link Fault Localizer

This block sits beside the decoder of a product-coded vertical link. It watches the row and column syndrome vectors produced for every received flit, and it never stalls traffic. A flit can point at a position only when exactly one row check and exactly one column check fail. Such a flit adds one to a saturating counter kept for that crossing position. Flits whose decoder reports more errors than it can place add no evidence, and neither do flits with an ambiguous syndrome.

A window counter counts valid flits. When the programmed number of valid flits has been seen, every position's count is compared with a programmable threshold. The resulting ROWS×COLS fault map is latched, a one-cycle window-done pulse is raised and all counters restart from zero. Intermittent defects flip bits only for some data values, so different flits reveal different faulty links. Across a window, several defects can therefore be located even though each flit locates at most one. A threshold above one filters out isolated soft errors.

Top module: `link_fault_localizer`

## Requirements
- R1: After reset, `fault_map` is all zeros and `window_done` is low.
- R2: A flit adds evidence only when `flit_valid` is high, `multi_err` is low, exactly one bit of `row_syn` is set and exactly one bit of `col_syn` is set. Every other flit adds none.
- R3: A qualifying flit with row bit i and column bit j set credits position (i,j), reported at `fault_map` bit i*COLS+j.
- R4: Every valid flit advances the window, qualifying or not. Cycles with `flit_valid` low do not advance it. `window_done` is high for exactly the one cycle after the clock edge that accepts the `win_len`-th valid flit. A `win_len` of 0 behaves as 1.
- R5: At window close, `fault_map` bit p becomes 1 exactly when position p's count for that window, including the closing flit, is at least `thres`. A `thres` of 0 marks every position.
- R6: All position counters restart from zero after a window closes, so evidence never carries into the next window.
- R7: Each position counter saturates at 2^CNT_W-1 and does not wrap.
- R8: A high `clr` on a clock edge zeroes all position counters and the window count and suppresses `window_done`. It takes priority over a window close in the same cycle.
- R9: `fault_map` changes only at a window close and otherwise holds its value, including across `clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous window restart |
| flit_valid | input | 1 | A flit was received this cycle |
| row_syn | input | ROWS | Row parity check failures |
| col_syn | input | COLS | Column parity check failures |
| multi_err | input | 1 | Decoder saw more errors than it can locate |
| thres | input | CNT_W | Marking threshold |
| win_len | input | WIN_W | Valid flits per window |
| fault_map | output | ROWS*COLS | Latched map of suspicious positions, bit i*COLS+j |
| window_done | output | 1 | One-cycle pulse after each window close |

## Verification
Two events can fall in the same cycle. The first is the window close coinciding with the closing flit's own evidence. The second is a restart request on the very edge that would close a window. The bench makes the closing flit the last needed hit for a threshold, and it expects that position to be marked. It also drives `clr` together with the `win_len`-th valid flit, then checks that no pulse appears and that the previous map is held. Random traffic over windows of varied length and threshold is compared each cycle against a bench model of counts and window position.

// File: rtl/lfl_pkg.sv
package lfl_pkg;
   // width of a counter that must hold values 0..max_val
   function automatic int width_for(input int max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction
endpackage

// File: rtl/lfl_qualify.sv
module lfl_qualify #(
   parameter int ROWS = 4,
   parameter int COLS = 4
) (
   input  logic            valid_i,
   input  logic            multi_i,
   input  logic [ROWS-1:0] row_i,
   input  logic [COLS-1:0] col_i,
   output logic [ROWS-1:0] row_sel_o,
   output logic [COLS-1:0] col_sel_o
);
   logic accept;

   always_comb begin
      accept    = valid_i && !multi_i && $onehot(row_i) && $onehot(col_i);
      row_sel_o = accept ? row_i : '0;
      col_sel_o = accept ? col_i : '0;
   end
endmodule

// File: rtl/lfl_cell.sv
module lfl_cell #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             zero_i,
   input  logic             hit_i,
   input  logic [CNT_W-1:0] thres_i,
   output logic             mark_o
);
   generate
      if (CNT_W == 1) begin : g_flag
         logic seen_q;
         logic seen_nxt;
         always_comb begin
            seen_nxt = seen_q | hit_i;
            mark_o   = ({1'b0, seen_nxt} >= {1'b0, thres_i});
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      seen_q <= 1'b0;
            else if (zero_i) seen_q <= 1'b0;
            else             seen_q <= seen_nxt;
         end
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;
         logic [CNT_W-1:0] cnt_nxt;
         always_comb begin
            if (hit_i && (cnt_q != {CNT_W{1'b1}})) cnt_nxt = cnt_q + 1'b1;
            else                                   cnt_nxt = cnt_q;
            mark_o = (cnt_nxt >= thres_i);
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cnt_q <= '0;
            else if (zero_i) cnt_q <= '0;
            else             cnt_q <= cnt_nxt;
         end
      end
   endgenerate
endmodule

// File: rtl/lfl_window.sv
module lfl_window #(
   parameter int WIN_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             valid_i,
   input  logic [WIN_W-1:0] len_i,
   output logic             close_o,
   output logic             done_o
);
   logic [WIN_W-1:0] seen_q;
   logic [WIN_W:0]   seen_inc;

   always_comb begin
      seen_inc = {1'b0, seen_q} + 1'b1;
      close_o  = valid_i && !clr_i && (seen_inc >= {1'b0, len_i});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= '0;
         done_o <= 1'b0;
      end else begin
         done_o <= close_o;
         if (clr_i || close_o) seen_q <= '0;
         else if (valid_i)     seen_q <= seen_inc[WIN_W-1:0];
      end
   end
endmodule

// File: rtl/link_fault_localizer.sv
module link_fault_localizer #(
   parameter int ROWS    = 4,
   parameter int COLS    = 4,
   parameter int CNT_W   = 4,
   parameter int WIN_MAX = 1024,
   parameter int WIN_W   = lfl_pkg::width_for(WIN_MAX)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 flit_valid,
   input  logic [ROWS-1:0]      row_syn,
   input  logic [COLS-1:0]      col_syn,
   input  logic                 multi_err,
   input  logic [CNT_W-1:0]     thres,
   input  logic [WIN_W-1:0]     win_len,
   output logic [ROWS*COLS-1:0] fault_map,
   output logic                 window_done
);
   localparam int POS = ROWS * COLS;

   if (ROWS < 1 || COLS < 1) begin : g_bad_dim
      $error("link_fault_localizer: ROWS and COLS must be positive");
   end
   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
      $error("link_fault_localizer: CNT_W out of range");
   end
   if (WIN_W < lfl_pkg::width_for(WIN_MAX)) begin : g_bad_win
      $error("link_fault_localizer: WIN_W too narrow for WIN_MAX");
   end

   logic [ROWS-1:0] row_sel;
   logic [COLS-1:0] col_sel;
   logic [POS-1:0]  mark;
   logic            close;

   lfl_qualify #(.ROWS(ROWS), .COLS(COLS)) u_qual (
      .valid_i   (flit_valid),
      .multi_i   (multi_err),
      .row_i     (row_syn),
      .col_i     (col_syn),
      .row_sel_o (row_sel),
      .col_sel_o (col_sel)
   );

   lfl_window #(.WIN_W(WIN_W)) u_win (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (clr),
      .valid_i (flit_valid),
      .len_i   (win_len),
      .close_o (close),
      .done_o  (window_done)
   );

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar c = 0; c < COLS; c++) begin : g_col
         lfl_cell #(.CNT_W(CNT_W)) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .zero_i  (clr | close),
            .hit_i   (row_sel[r] & col_sel[c]),
            .thres_i (thres),
            .mark_o  (mark[r*COLS+c])
         );
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     fault_map <= '0;
      else if (close) fault_map <= mark;
   end
endmodule

// File: rtl/lfl_checker.sv
module lfl_checker #(
   parameter int ROWS  = 4,
   parameter int COLS  = 4,
   parameter int CNT_W = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 clr,
   input logic                 flit_valid,
   input logic [CNT_W-1:0]     thres,
   input logic [ROWS*COLS-1:0] fault_map,
   input logic                 window_done
);
   // R4
   done_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      window_done |-> $past(flit_valid));
   // R8
   clr_blocks_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr) |-> !window_done);
   // R9
   map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !window_done |-> $stable(fault_map));
   // R5
   zero_thres_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (window_done && ($past(thres) == '0)) |-> (&fault_map));
   // R1
   reset_state_chk: assert property (@(posedge clk)
      !rst_n |=> (fault_map == '0 || rst_n));
endmodule

bind link_fault_localizer lfl_checker #(.ROWS(ROWS), .COLS(COLS), .CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .clr         (clr),
   .flit_valid  (flit_valid),
   .thres       (thres),
   .fault_map   (fault_map),
   .window_done (window_done)
);

// File: tb/link_fault_localizer_tb.sv
module link_fault_localizer_tb;
   localparam int ROWS = 4, COLS = 4, CNT_W = 4, WIN_MAX = 1024;
   localparam int WIN_W = lfl_pkg::width_for(WIN_MAX);
   localparam int POS = ROWS * COLS;
   localparam int SAT = (1 << CNT_W) - 1;

   logic clk = 0, rst_n = 0, clr = 0, flit_valid = 0, multi_err = 0;
   logic [ROWS-1:0] row_syn = '0;
   logic [COLS-1:0] col_syn = '0;
   logic [CNT_W-1:0] thres = 1;
   logic [WIN_W-1:0] win_len = 8;
   logic [POS-1:0] fault_map;
   logic window_done;

   always #2ns clk = ~clk;

   link_fault_localizer #(.ROWS(ROWS), .COLS(COLS), .CNT_W(CNT_W), .WIN_MAX(WIN_MAX)) u_dut (
      .clk(clk), .rst_n(rst_n), .clr(clr), .flit_valid(flit_valid), .row_syn(row_syn),
      .col_syn(col_syn), .multi_err(multi_err), .thres(thres), .win_len(win_len),
      .fault_map(fault_map), .window_done(window_done));

   int n_chk = 0, n_fail = 0;
   int cnt[POS];
   int wcnt = 0;
   logic [POS-1:0] emap = '0;
   logic edone = 0;
   bit finished = 0;

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic bit one_hot(input logic [7:0] v);
      return $countones(v) == 1;
   endfunction

   function automatic int pos_of(input logic [ROWS-1:0] r, input logic [COLS-1:0] c);
      int ri = 0, ci = 0;
      for (int i = 0; i < ROWS; i++) if (r[i]) ri = i;
      for (int j = 0; j < COLS; j++) if (c[j]) ci = j;
      return ri * COLS + ci;
   endfunction

   task automatic model_clear();
      for (int p = 0; p < POS; p++) cnt[p] = 0;
      wcnt = 0;
   endtask

   task automatic cyc(input bit v, input logic [ROWS-1:0] r, input logic [COLS-1:0] c,
                      input bit m, input bit cl);
      int lim;
      @(negedge clk);
      flit_valid = v; row_syn = r; col_syn = c; multi_err = m; clr = cl;
      edone = 0;
      if (cl) model_clear();
      else begin
         if (v && !m && one_hot(8'(r)) && one_hot(8'(c))) begin
            int p = pos_of(r, c);
            if (cnt[p] < SAT) cnt[p]++;
         end
         if (v) begin
            wcnt++;
            lim = (win_len == 0) ? 1 : int'(win_len);
            if (wcnt >= lim) begin
               for (int p = 0; p < POS; p++) emap[p] = (cnt[p] >= int'(thres));
               model_clear();
               edone = 1;
            end
         end
      end
      @(posedge clk); #1;
      check("R4 window_done", 64'(window_done), 64'(edone));
      check("R9 fault_map", 64'(fault_map), 64'(emap));
      @(negedge clk);
      flit_valid = 0; clr = 0; multi_err = 0; row_syn = '0; col_syn = '0;
   endtask

   task automatic hit(input int i, input int j);
      cyc(1, ROWS'(1) << i, COLS'(1) << j, 0, 0);
   endtask

   task automatic idle_valid(input int n);
      for (int k = 0; k < n; k++) cyc(1, '0, '0, 0, 0);
   endtask

   initial begin
      repeat (400000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      model_clear();
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      check("R1 map at reset", 64'(fault_map), 0);
      check("R1 done at reset", 64'(window_done), 0);
      @(negedge clk); rst_n = 1;

      // R2 R3: window of 8, thres 1
      win_len = 8; thres = 1;
      hit(1, 2);
      cyc(1, 4'b0001, 4'b0001, 1, 0);      // multi_err: ignored
      cyc(1, 4'b0011, 4'b0100, 0, 0);      // two rows: ignored
      cyc(0, 4'b1000, 4'b1000, 0, 0);      // not valid: ignored, no advance
      cyc(1, 4'b1000, 4'b0000, 0, 0);      // no column: ignored
      idle_valid(4);
      check("R2 only qualifying flit marks", 64'(fault_map), 64'(1) << 6);
      check("R3 position index i*COLS+j", 64'(fault_map[1*COLS+2]), 1);

      // R5 R6: thres 3, closing flit is the third hit
      thres = 3;
      hit(0, 0); hit(0, 0); hit(3, 3); hit(3, 3); idle_valid(3); hit(3, 3);
      check("R5 closing flit counted", 64'(fault_map), 64'(1) << 15);
      // R6 evidence does not carry over
      hit(3, 3); idle_valid(7);
      check("R6 counters restarted", 64'(fault_map), 0);

      // R7 saturation: 20 hits, thres 15
      win_len = 20; thres = 15;
      for (int k = 0; k < 20; k++) hit(2, 1);
      check("R7 saturating count", 64'(fault_map), 64'(1) << 9);

      // R5 thres 0 marks all
      thres = 0; win_len = 3; idle_valid(3);
      check("R5 zero threshold", 64'(fault_map), {POS{1'b1}});

      // R8 clr mid-window, map held
      thres = 1; win_len = 5;
      hit(0, 1); hit(0, 1);
      cyc(0, '0, '0, 0, 1);
      check("R8 map held across clr", 64'(fault_map), {POS{1'b1}});
      idle_valid(5);
      check("R8 clr discarded evidence", 64'(fault_map), 0);
      // R8 clr on the closing flit
      hit(2, 2); idle_valid(3);
      cyc(1, 4'b0100, 4'b0100, 0, 1);
      check("R8 clr beats close", 64'(window_done), 0);
      idle_valid(5);
      check("R8 new window after clr", 64'(fault_map), 0);

      // R4 win_len 0 behaves as 1
      win_len = 0;
      hit(3, 0);
      check("R4 length zero", 64'(fault_map), 64'(1) << 12);

      // random traffic
      void'($urandom(32'h5eed_1234));
      for (int w = 0; w < 40; w++) begin
         win_len = WIN_W'(16 + $urandom_range(0, 24));
         thres = CNT_W'($urandom_range(1, 3));
         cyc(0, '0, '0, 0, 1);
         for (int k = 0; k < 60; k++) begin
            int sel = $urandom_range(0, 9);
            logic [ROWS-1:0] r = ROWS'(1) << $urandom_range(0, ROWS - 1);
            logic [COLS-1:0] c = COLS'(1) << $urandom_range(0, COLS - 1);
            if (sel < 6)       cyc(1, r, c, 0, 0);
            else if (sel == 6) cyc(1, r, c, 1, 0);
            else if (sel == 7) cyc(1, r | ROWS'(1), c, 0, 0);
            else if (sel == 8) cyc(0, r, c, 0, 0);
            else               cyc(1, '0, '0, 0, 0);
         end
      end

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule